// File: doc/BRIEF.md
# Periodic Compare/Capture Timer

A general-purpose counter with two compare registers, A and P, and a capture register. Software sets the clock source, operating mode, match behaviour and capture options through a small register port. The counter advances on ticks. A tick comes either from an internal power-of-two divider of the system clock or from an active edge on the external clock pin. The block drives two output pins and two sticky interrupt flags.

Four modes share one state machine. In compare-output mode each pin takes an action on a compare match. PWM mode uses P for the period and A for the duty point. Single-pulse mode waits for an edge on the external pin, then drives one pulse. Capture mode latches the counter when a chosen edge arrives on either of two inputs.

The controller has four states:
- IDLE: the counter is held at zero.
- COUNT: used by the compare, PWM and capture modes.
- ARMED: waits for a trigger.
- PULSE: the pulse is being driven.

The transitions are:
- start: IDLE to COUNT, when run is set and the mode is not single-pulse.
- arm: IDLE to ARMED, when run is set in single-pulse mode.
- trigger: ARMED to PULSE, on an active edge of the external pin.
- pulse end: PULSE to ARMED, on the A match.
- stop: any state to IDLE, when run is cleared or the mode no longer fits the state.

Top module: `periodic_timer`

## Requirements
- R1: After reset every readable register (control at address 0, A at 1, P at 2, counter at 3, capture at 4, flags at 5) reads zero, and both pins and both flags are low.
- R2: Control bits [2:0] select the clock. A value s from 0 to 5 gives one tick every 2^s cycles. A match occurs when the counter equals P on a tick. When control bit 7 is 0, a P match clears the counter and sets flag P (flag bit 1). Flag P is first visible 1+(P+1)*2^s cycles after the clock edge that writes run (control bit 6).
- R3: When control bit 7 is 1, the A match clears the counter instead, and sets flag A (flag bit 0) 2+A cycles after the run write at divide-by-1. A value of P above A is then never reached.
- R4: In compare mode (control bits [5:4]=0), an A match applies the 2-bit action in bits [9:8] to output 0. A P match applies the action in bits [11:10] to output 1. Action codes: 00 hold, 01 drive low, 10 drive high, 11 toggle.
- R5: In PWM mode ([5:4]=1), P matches end the period, which is P+1 ticks. Output 0 is high while the counter is below A. Output 1 is its complement while running.
- R6: Clock select 6 takes ticks from the external pin through a two-flop synchronizer. Control bit 3 picks the active edge: 0 rising, 1 falling. Each active edge advances the counter exactly once, and the other edge has no effect.
- R7: In single-pulse mode ([5:4]=2), an active edge of the external pin (edge set by bit 3) starts a pulse on output 0 that lasts A+1 ticks, after which the block re-arms. A steady high level does not retrigger. Edges that arrive during a pulse are ignored.
- R8: In capture mode ([5:4]=3), bit 14 selects the source: 0 the external pin, 1 the auxiliary pin. Bits [13:12] select the edge: 00 rising, 01 falling, 10 both. On a selected edge the counter value is latched into the capture register, on the cycle the synchronized edge is seen, and flag A is set. Non-selected edges change neither.
- R9: Flags stay set until software writes 1 to the matching bit of address 5. Writing 0 leaves a flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| tck_in | input | 1 | External clock, trigger and capture pin |
| aux_in | input | 1 | Second capture-capable input |
| pin_out0 | output | 1 | Output 0 (A action, PWM, pulse) |
| pin_out1 | output | 1 | Output 1 (P action, PWM complement) |
| irq_a | output | 1 | Sticky flag A |
| irq_p | output | 1 | Sticky flag P |

## Verification
Once the run write lands, the controller enters COUNT one edge later. The k-th divided tick then advances the counter at edge 1+k*2^s. Each match result shows up one edge after the tick on which the counter equals the compare value. An external edge takes three edges to act: two synchronizer flops, then the register it updates. So a capture holds the counter value seen two edges after the pin changed, and a pulse starts on the third edge. The bench drives every input at a falling clock edge, counts rising edges from the write, and samples outputs at the following falling edge, where these counts say the result is due.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int CTRL_W = 16;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_CMPA = 3'd1;
    localparam logic [2:0] A_CMPP = 3'd2;
    localparam logic [2:0] A_CNT  = 3'd3;
    localparam logic [2:0] A_CAP  = 3'd4;
    localparam logic [2:0] A_FLAG = 3'd5;

    localparam logic [2:0] SEL_EXT = 3'd6;

    typedef enum logic [1:0] {
        M_CMP   = 2'd0,
        M_PWM   = 2'd1,
        M_PULSE = 2'd2,
        M_CAPT  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_ARMED,
        ST_PULSE
    } state_e;

    typedef struct packed {
        logic       spare;
        logic       cap_src;
        logic [1:0] cap_edge;
        logic [1:0] act1;
        logic [1:0] act0;
        logic       clr_on_a;
        logic       run;
        mode_e      mode;
        logic       ext_fall;
        logic [2:0] clk_sel;
    } ctrl_t;

    function automatic logic pin_action(input logic cur, input logic [1:0] act);
        case (act)
            2'b00:   pin_action = cur;
            2'b01:   pin_action = 1'b0;
            2'b10:   pin_action = 1'b1;
            default: pin_action = ~cur;
        endcase
    endfunction

endpackage

// File: rtl/ptmr_edge_sync.sv
module ptmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];

    // R6: one input transition yields a single-cycle rise event
    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise) else $error("rise event lasted two cycles");

endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int NUM_DIV = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam int PW = (NUM_DIV > 1) ? NUM_DIV - 1 : 1;

    logic [PW-1:0] pre;
    logic [PW-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pre <= '0;
        else if (!en) pre <= '0;
        else          pre <= pre + 1'b1;
    end

    always_comb begin
        mask = PW'((32'd1 << sel) - 32'd1);
        tick = (int'(sel) < NUM_DIV) && ((pre & mask) == mask);
    end

endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  mode_e         mode,
    input  logic          clr_on_a,
    input  logic [1:0]    act0,
    input  logic [1:0]    act1,
    input  logic          tick,
    input  logic          trig,
    input  logic [DW-1:0] cmpa,
    input  logic [DW-1:0] cmpp,
    output logic [DW-1:0] cnt,
    output logic          match_a,
    output logic          match_p,
    output logic          counting,
    output logic          active,
    output logic          pin0,
    output logic          pin1
);
    state_e        state_q, state_d;
    logic [DW-1:0] cnt_q;
    logic          o0_q, o1_q;
    logic          clr_hit;
    logic          pwm_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign match_a  = tick && (cnt_q == cmpa) &&
                      (state_q == ST_COUNT || state_q == ST_PULSE);
    assign match_p  = tick && (cnt_q == cmpp) && (state_q == ST_COUNT);
    assign clr_hit  = (mode == M_PWM) ? match_p : (clr_on_a ? match_a : match_p);
    assign counting = (state_q == ST_COUNT);
    assign active   = (state_q != ST_IDLE);
    assign cnt      = cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run) state_d = (mode == M_PULSE) ? ST_ARMED : ST_COUNT;
            ST_COUNT: if (!run || mode == M_PULSE) state_d = ST_IDLE;
            ST_ARMED: if (!run || mode != M_PULSE) state_d = ST_IDLE;
                      else if (trig)               state_d = ST_PULSE;
            ST_PULSE: if (!run || mode != M_PULSE) state_d = ST_IDLE;
                      else if (match_a)            state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            o0_q  <= 1'b0;
            o1_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_COUNT: begin
                    if (clr_hit)   cnt_q <= '0;
                    else if (tick) cnt_q <= cnt_q + 1'b1;
                    if (mode == M_CMP) begin
                        if (match_a) o0_q <= pin_action(o0_q, act0);
                        if (match_p) o1_q <= pin_action(o1_q, act1);
                    end
                end
                ST_PULSE: begin
                    if (match_a)   cnt_q <= '0;
                    else if (tick) cnt_q <= cnt_q + 1'b1;
                end
                default: begin
                    cnt_q <= '0;
                    o0_q  <= 1'b0;
                    o1_q  <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        pin0   = 1'b0;
        pin1   = 1'b0;
        pwm_hi = (cnt_q < cmpa);
        unique case (state_q)
            ST_COUNT: begin
                if (mode == M_PWM) begin
                    pin0 = pwm_hi;
                    pin1 = ~pwm_hi;
                end else if (mode == M_CMP) begin
                    pin0 = o0_q;
                    pin1 = o1_q;
                end
            end
            ST_PULSE: pin0 = 1'b1;
            default: ;
        endcase
    end

    assert_clear_on_p_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (match_p && (mode == M_PWM || !clr_on_a)) |=> (cnt_q == '0))
        else $error("counter not cleared after P match");

    assert_clear_on_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && mode == M_CMP && clr_on_a && match_a) |=> (cnt_q == '0))
        else $error("counter not cleared after A match");

    assert_set_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_a && run && mode == M_CMP && act0 == 2'b10) |=> (pin0 || mode != M_CMP))
        else $error("set action did not drive output 0 high");

    assert_pwm_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_p && run && mode == M_PWM) |=> (mode != M_PWM || pin0 == (cmpa != '0)))
        else $error("PWM period restart level wrong");

    assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && run && mode == M_PULSE && trig) |=> (pin0 && cnt_q == '0))
        else $error("pulse did not start on trigger");

endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
    import ptmr_pkg::*;
#(
    parameter int DW          = 16,
    parameter int NUM_DIV     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          tck_in,
    input  logic          aux_in,
    output logic          pin_out0,
    output logic          pin_out1,
    output logic          irq_a,
    output logic          irq_p
);
    localparam int NPIN = 2;

    ctrl_t           ctrl_q;
    logic [DW-1:0]   cmpa_q, cmpp_q, cap_q, cnt;
    logic [1:0]      flag_q, flag_clr, flag_set;
    logic [NPIN-1:0] pin_in, rise, fall;
    logic            ext_edge, pre_tick, tick;
    logic            match_a, match_p, counting, active;
    logic            cap_r, cap_f, cap_hit, cap_evt;

    assign pin_in = {aux_in, tck_in};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        ptmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_in[g]),
            .rise (rise[g]),
            .fall (fall[g])
        );
    end

    ptmr_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (active),
        .sel  (ctrl_q.clk_sel),
        .tick (pre_tick)
    );

    assign ext_edge = ctrl_q.ext_fall ? fall[0] : rise[0];
    assign tick     = (ctrl_q.clk_sel == SEL_EXT) ? ext_edge : pre_tick;

    ptmr_core #(.DW(DW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.run),
        .mode    (ctrl_q.mode),
        .clr_on_a(ctrl_q.clr_on_a),
        .act0    (ctrl_q.act0),
        .act1    (ctrl_q.act1),
        .tick    (tick),
        .trig    (ext_edge),
        .cmpa    (cmpa_q),
        .cmpp    (cmpp_q),
        .cnt     (cnt),
        .match_a (match_a),
        .match_p (match_p),
        .counting(counting),
        .active  (active),
        .pin0    (pin_out0),
        .pin1    (pin_out1)
    );

    assign cap_r = ctrl_q.cap_src ? rise[1] : rise[0];
    assign cap_f = ctrl_q.cap_src ? fall[1] : fall[0];

    always_comb begin
        unique case (ctrl_q.cap_edge)
            2'b00:   cap_hit = cap_r;
            2'b01:   cap_hit = cap_f;
            2'b10:   cap_hit = cap_r | cap_f;
            default: cap_hit = 1'b0;
        endcase
    end

    assign cap_evt     = counting && (ctrl_q.mode == M_CAPT) && cap_hit;
    assign flag_set[0] = (ctrl_q.mode == M_CAPT) ? cap_evt : match_a;
    assign flag_set[1] = match_p;
    assign flag_clr    = (wr_en && addr == A_FLAG) ? wdata[1:0] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmpa_q <= '0;
            cmpp_q <= '0;
            cap_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_en && addr == A_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_en && addr == A_CMPA) cmpa_q <= wdata;
            if (wr_en && addr == A_CMPP) cmpp_q <= wdata;
            if (cap_evt)                 cap_q  <= cnt;
            flag_q <= flag_set | (flag_q & ~flag_clr);
        end
    end

    assign irq_a = flag_q[0];
    assign irq_p = flag_q[1];

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
            A_CMPA:  rdata = cmpa_q;
            A_CMPP:  rdata = cmpp_q;
            A_CNT:   rdata = cnt;
            A_CAP:   rdata = cap_q;
            A_FLAG:  rdata[1:0] = flag_q;
            default: rdata = '0;
        endcase
    end

    assert_ext_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && ctrl_q.run && ctrl_q.mode != M_PULSE &&
         ctrl_q.clk_sel == SEL_EXT && !ext_edge) |=> $stable(cnt))
        else $error("counter moved without an external edge");

    assert_capture_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_q == $past(cnt)))
        else $error("capture register does not hold the counter value");

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !(wr_en && addr == A_FLAG && wdata[0])) |=> flag_q[0])
        else $error("flag A dropped without a clearing write");

endmodule

// File: tb/tb_periodic_timer.sv
module tb_periodic_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        tck_in = 1'b0;
    logic        aux_in = 1'b0;
    logic        pin_out0, pin_out1, irq_a, irq_p;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    periodic_timer dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .tck_in  (tck_in),
        .aux_in  (aux_in),
        .pin_out0(pin_out0),
        .pin_out1(pin_out1),
        .irq_a   (irq_a),
        .irq_p   (irq_p)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = 16'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic stop_clear();
        wr(3'd0, 0);
        wr(3'd5, 3);
    endtask

    function automatic int mk(int sel, int fall, int mode, int run, int clra,
                              int a0, int a1, int ce, int cs);
        return sel | (fall << 3) | (mode << 4) | (run << 6) | (clra << 7) |
               (a0 << 8) | (a1 << 10) | (ce << 12) | (cs << 14);
    endfunction

    task automatic poll(input bit use_p, output int n);
        bit hit;
        n = 0;
        hit = 1'b0;
        while (n < 300 && !hit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            hit = use_p ? irq_p : irq_a;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, c, n, h0, h1, capprev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reg %0d after reset", a), v, 0);
        end
        chk("R1 pins/flags after reset", int'({pin_out0, pin_out1, irq_a, irq_p}), 0);

        // R2 divided clock and P period
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 6; p++) begin
                stop_clear();
                wr(3'd2, p);
                wr(3'd0, mk(s, 0, 0, 1, 0, 0, 0, 0, 0));
                poll(1'b1, n);
                chk($sformatf("R2 first P flag s=%0d P=%0d", s, p), n, 1 + ((p + 1) << s));
            end
        end

        // R3 clear on A
        for (int a = 0; a < 6; a += 2) begin
            stop_clear();
            wr(3'd1, a);
            wr(3'd2, a + 3);
            wr(3'd0, mk(0, 0, 0, 1, 1, 0, 0, 0, 0));
            poll(1'b0, n);
            chk($sformatf("R3 first A flag A=%0d", a), n, a + 2);
            repeat (30) @(negedge clk);
            chk($sformatf("R3 P never reached A=%0d", a), int'(irq_p), 0);
        end

        // R4 compare pin actions, A=1 P=3
        for (int code = 0; code < 4; code++) begin
            stop_clear();
            wr(3'd1, 1);
            wr(3'd2, 3);
            wr(3'd0, mk(0, 0, 0, 1, 0, code, code, 0, 0));
            repeat (6) @(posedge clk);
            @(negedge clk);
            chk($sformatf("R4 out0 first match code=%0d", code), int'(pin_out0), int'(code >= 2));
            chk($sformatf("R4 out1 first match code=%0d", code), int'(pin_out1), int'(code >= 2));
            repeat (4) @(posedge clk);
            @(negedge clk);
            chk($sformatf("R4 out0 second match code=%0d", code), int'(pin_out0), int'(code == 2));
            chk($sformatf("R4 out1 second match code=%0d", code), int'(pin_out1), int'(code == 2));
        end

        // R5 PWM duty sweep
        for (int p = 3; p <= 5; p += 2) begin
            for (int a = 0; a <= p + 1; a++) begin
                stop_clear();
                wr(3'd1, a);
                wr(3'd2, p);
                wr(3'd0, mk(0, 0, 1, 1, 0, 0, 0, 0, 0));
                repeat (3) @(negedge clk);
                h0 = 0;
                h1 = 0;
                repeat (2 * (p + 1)) begin
                    @(posedge clk);
                    @(negedge clk);
                    h0 += int'(pin_out0);
                    h1 += int'(pin_out1);
                end
                chk($sformatf("R5 out0 high count P=%0d A=%0d", p, a), h0, 2 * ((a < p + 1) ? a : p + 1));
                chk($sformatf("R5 out1 high count P=%0d A=%0d", p, a), h1,
                    2 * (p + 1) - 2 * ((a < p + 1) ? a : p + 1));
            end
        end

        // R6 external clock, rising then falling
        stop_clear();
        wr(3'd2, 100);
        wr(3'd0, mk(6, 0, 0, 1, 0, 0, 0, 0, 0));
        repeat (4) begin
            tck_in = 1'b1;
            repeat (3) @(negedge clk);
            tck_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(3'd3, v);
        chk("R6 rising edges counted", v, 4);
        stop_clear();
        wr(3'd0, mk(6, 1, 0, 1, 0, 0, 0, 0, 0));
        tck_in = 1'b1;
        repeat (6) @(negedge clk);
        rd(3'd3, v);
        chk("R6 rising edge ignored when falling selected", v, 0);
        tck_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(3'd3, v);
        chk("R6 falling edge counted", v, 1);

        // R7 single pulse widths and level without retrigger
        for (int w = 0; w < 5; w++) begin
            stop_clear();
            wr(3'd1, w);
            wr(3'd0, mk(0, 0, 2, 1, 0, 0, 0, 0, 0));
            repeat (4) @(negedge clk);
            tck_in = 1'b1;
            h0 = 0;
            repeat (20) begin
                @(posedge clk);
                @(negedge clk);
                h0 += int'(pin_out0);
            end
            chk($sformatf("R7 pulse width A=%0d", w), h0, w + 1);
            h1 = 0;
            repeat (20) begin
                @(posedge clk);
                @(negedge clk);
                h1 += int'(pin_out0);
            end
            chk($sformatf("R7 held level no retrigger A=%0d", w), h1, 0);
            tck_in = 1'b0;
            repeat (4) @(negedge clk);
        end
        stop_clear();
        wr(3'd1, 8);
        wr(3'd0, mk(0, 0, 2, 1, 0, 0, 0, 0, 0));
        repeat (4) @(negedge clk);
        tck_in = 1'b1;
        h0 = 0;
        for (int i = 1; i <= 30; i++) begin
            @(posedge clk);
            @(negedge clk);
            h0 += int'(pin_out0);
            if (i == 4) tck_in = 1'b0;
            if (i == 6) tck_in = 1'b1;
        end
        chk("R7 edge during pulse ignored", h0, 9);
        tck_in = 1'b0;
        repeat (4) @(negedge clk);

        // R8 capture sweep over source, edge select and direction
        stop_clear();
        wr(3'd2, 1000);
        capprev = 0;
        for (int cs = 0; cs < 2; cs++) begin
            for (int ce = 0; ce < 3; ce++) begin
                stop_clear();
                wr(3'd0, mk(0, 0, 3, 1, 0, 0, 0, ce, cs));
                repeat (5) @(negedge clk);
                for (int dir = 0; dir < 2; dir++) begin
                    bit hit;
                    wr(3'd5, 3);
                    rd(3'd3, c);
                    if (cs == 0) tck_in = (dir == 0);
                    else         aux_in = (dir == 0);
                    repeat (6) @(negedge clk);
                    hit = (ce == 0 && dir == 0) || (ce == 1 && dir == 1) || (ce == 2);
                    if (hit) capprev = c + 2;
                    rd(3'd4, v);
                    chk($sformatf("R8 capture value src=%0d edge=%0d dir=%0d", cs, ce, dir), v, capprev);
                    chk($sformatf("R8 capture flag src=%0d edge=%0d dir=%0d", cs, ce, dir),
                        int'(irq_a), int'(hit));
                end
            end
        end

        // R9 sticky flags and write-one-to-clear
        stop_clear();
        wr(3'd1, 1);
        wr(3'd2, 2);
        wr(3'd0, mk(0, 0, 0, 1, 0, 0, 0, 0, 0));
        repeat (10) @(negedge clk);
        wr(3'd0, 0);
        repeat (3) @(negedge clk);
        rd(3'd5, v);
        chk("R9 flags held after stop", v, 3);
        wr(3'd5, 0);
        rd(3'd5, v);
        chk("R9 write zero keeps flags", v, 3);
        wr(3'd5, 1);
        rd(3'd5, v);
        chk("R9 clear A only", v, 2);
        wr(3'd5, 2);
        rd(3'd5, v);
        chk("R9 clear P", v, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule